// File: doc/BRIEF.md
# Four-Phase Memory Handshake Master

This block lets a core perform one word read or write at a time on a memory that answers through an interlocked four-phase handshake. The core pulses `start_i` with a direction, an address and, for writes, a data word. The block raises `req_o`, waits for the memory to pull the active-low `wait_n_i` line down, drops `req_o`, and waits for `wait_n_i` to go high again. Only then is the transfer finished, and `done_o` pulses for one cycle.

While the memory holds `wait_n_i` low, read data is captured into `rdata_o`. On writes the block enables its data-bus driver from the moment the request rises until the wait line is seen high again. On reads that driver stays off for the whole transfer, so the master and the memory never drive the shared bus together. The wait line passes through a synchronizer of selectable depth.

An optional timeout drops the request when no acknowledge arrives within a run-time limit. The transfer then ends with `err_o` set alongside `done_o`.

Top module: `hs_bus_master`

## Requirements
- R1: After reset, `req_o`, `bus_oe_o`, `done_o`, `err_o` and `busy_o` are all 0. Whenever `busy_o` is 0, `req_o` and `bus_oe_o` are also 0.
- R2: A `start_i` pulse seen while `busy_o` is 0 makes `req_o` and `busy_o` 1 in the next cycle. In that cycle `addr_o` equals the given address and `rnw_o` is 1 for a read and 0 for a write (`write_i` = 1 selects write).
- R3: `addr_o`, `rnw_o` and `bus_wdata_o` stay unchanged from the cycle `req_o` rises until the cycle `done_o` pulses.
- R4: `req_o` stays high until a low `wait_n_i` has passed the SYNC_STAGES-deep synchronizer. It falls SYNC_STAGES+1 cycles after the memory first drives `wait_n_i` low.
- R5: On a read, the word on `bus_rdata_i` is captured while the synchronized wait line is low. After `done_o`, `rdata_o` holds the addressed memory word.
- R6: `bus_oe_o` is 1 only on writes, from the rise of `req_o` until the synchronized wait line returns high. It is never 1 while the memory drives read data. The memory receives `bus_wdata_o` at its acknowledge.
- R7: `done_o` is a single-cycle pulse that occurs only once the synchronized wait line is high again after the request dropped. `busy_o` is 0 in that same cycle.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored: no second memory transfer takes place.
- R9: With TMO_EN set and `tmo_limit_i` = N > 0, a request that receives no acknowledge stays high for exactly N cycles and then falls. The transfer ends with `err_o` = 1 in the same cycle as `done_o`. In every other cycle `err_o` is 0.
- R10: With `tmo_limit_i` = 0 the timeout is disabled, and a request waits for the acknowledge indefinitely.
- R11: When the acknowledge becomes visible in the same cycle as the timeout expires, the acknowledge wins. The transfer completes normally with `err_o` = 0 and valid read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transfer request pulse from the core |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| tmo_limit_i | input | TMO_W | Acknowledge timeout in cycles, 0 = off |
| req_o | output | 1 | Handshake request to memory |
| rnw_o | output | 1 | Direction to memory, 1 = read |
| addr_o | output | ADDR_W | Address to memory |
| bus_oe_o | output | 1 | Data-bus driver enable |
| bus_wdata_o | output | DATA_W | Data driven onto the bus when enabled |
| bus_rdata_i | input | DATA_W | Data bus as driven by memory |
| wait_n_i | input | 1 | Active-low wait from memory, high at idle |
| rdata_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Transfer in progress |
| err_o | output | 1 | Timeout flag, valid with done_o |

## Verification
The acknowledge and the timeout expiry can land in the same cycle. That happens when the synchronized wait line first reads low in the very cycle the cycle counter reaches its limit. The bench provokes the tie with a memory model that acknowledges with zero delay. With SYNC_STAGES = 2, the ack then becomes visible in the fourth request cycle. A read with a limit of 4 must finish without error and return the stored word. A read with a limit of 3 must time out and report an error. A second overlap, a start pulse arriving while a transfer is in flight, is judged by counting the transfers the memory model actually serves.

// File: rtl/hs_pkg.sv
package hs_pkg;

   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,   // no transfer
      HS_REQ  = 2'd1,   // request high, waiting for wait low
      HS_REL  = 2'd2    // request low, waiting for wait high
   } hs_state_e;

endpackage

// File: rtl/hs_wait_sync.sv
module hs_wait_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_n_i,
   output logic wait_n_o
);

   if (STAGES == 0) begin : g_direct
      assign wait_n_o = wait_n_i;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '1;   // idle level of wait is high
         else        sh_q <= {sh_q[STAGES-2+((STAGES==1)?1:0):0], wait_n_i} ;
      end
      assign wait_n_o = sh_q[STAGES-1];
   end

endmodule

// File: rtl/hs_timeout.sv
module hs_timeout #(
   parameter bit ENABLE = 1'b1,
   parameter int CNT_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             hit_o
);

   if (ENABLE) begin : g_on
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt_q <= '0;
         else if (!run_i) cnt_q <= '0;
         else if (!hit_o) cnt_q <= cnt_q + 1'b1;
      end
      // expiry on the limit-th cycle of the run window
      assign hit_o = run_i && (limit_i != '0) && (cnt_q == limit_i - 1'b1);
   end else begin : g_off
      assign hit_o = 1'b0;
   end

endmodule

// File: rtl/hs_seq.sv
module hs_seq
   import hs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   input  logic      wait_n_s,
   input  logic      tmo_hit_i,
   output hs_state_e state_o,
   output logic      launch_o,
   output logic      ack_o,
   output logic      tmo_o,
   output logic      finish_o
);

   hs_state_e st_q, st_d;

   always_comb begin
      st_d     = st_q;
      launch_o = 1'b0;
      ack_o    = 1'b0;
      tmo_o    = 1'b0;
      finish_o = 1'b0;
      unique case (st_q)
         HS_IDLE: if (start_i) begin
            launch_o = 1'b1;
            st_d     = HS_REQ;
         end
         HS_REQ: begin
            // acknowledge takes priority over a coincident expiry (R11)
            if (!wait_n_s) begin
               ack_o = 1'b1;
               st_d  = HS_REL;
            end else if (tmo_hit_i) begin
               tmo_o = 1'b1;
               st_d  = HS_REL;
            end
         end
         HS_REL: if (wait_n_s) begin
            finish_o = 1'b1;
            st_d     = HS_IDLE;
         end
         default: st_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= HS_IDLE;
      else        st_q <= st_d;
   end

   assign state_o = st_q;

endmodule

// File: rtl/hs_bus_master.sv
module hs_bus_master
   import hs_pkg::*;
#(
   parameter int ADDR_W      = 14,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit TMO_EN      = 1'b1,
   parameter int TMO_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              write_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [TMO_W-1:0]  tmo_limit_i,
   output logic              req_o,
   output logic              rnw_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              bus_oe_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic [DATA_W-1:0] bus_rdata_i,
   input  logic              wait_n_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              done_o,
   output logic              busy_o,
   output logic              err_o
);

   if (ADDR_W < 1)                        begin : g_bad_aw  $error("ADDR_W must be positive");        end
   if (DATA_W < 1)                        begin : g_bad_dw  $error("DATA_W must be positive");        end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sy  $error("SYNC_STAGES must be 0 to 4");   end
   if (TMO_W < 2)                         begin : g_bad_tw  $error("TMO_W must be at least 2");      end

   logic      wait_n_s;
   logic      tmo_hit;
   hs_state_e state;
   logic      launch, ack, tmo, finish;

   hs_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .wait_n_i (wait_n_i),
      .wait_n_o (wait_n_s)
   );

   hs_timeout #(.ENABLE(TMO_EN), .CNT_W(TMO_W)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (state == HS_REQ),
      .limit_i (tmo_limit_i),
      .hit_o   (tmo_hit)
   );

   hs_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .wait_n_s  (wait_n_s),
      .tmo_hit_i (tmo_hit),
      .state_o   (state),
      .launch_o  (launch),
      .ack_o     (ack),
      .tmo_o     (tmo),
      .finish_o  (finish)
   );

   logic [ADDR_W-1:0] addr_q;
   logic              rnw_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              err_pend_q, err_q, done_q;

   // request parameters are frozen at launch (R3)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         rnw_q   <= 1'b1;
         wdata_q <= '0;
      end else if (launch) begin
         addr_q  <= addr_i;
         rnw_q   <= !write_i;
         wdata_q <= wdata_i;
      end
   end

   // read capture while wait is low (R5)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rdata_q <= '0;
      else if (ack && rnw_q)   rdata_q <= bus_rdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_pend_q <= 1'b0;
         err_q      <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         done_q <= finish;
         err_q  <= finish && err_pend_q;
         if (tmo)         err_pend_q <= 1'b1;
         else if (finish) err_pend_q <= 1'b0;
      end
   end

   assign req_o       = (state == HS_REQ);
   assign busy_o      = (state != HS_IDLE);
   assign bus_oe_o    = busy_o && !rnw_q;
   assign rnw_o       = rnw_q;
   assign addr_o      = addr_q;
   assign bus_wdata_o = wdata_q;
   assign rdata_o     = rdata_q;
   assign done_o      = done_q;
   assign err_o       = err_q;

endmodule

// File: rtl/hs_bus_master_chk.sv
module hs_bus_master_chk #(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              req_o,
   input logic              rnw_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic [DATA_W-1:0] bus_wdata_o,
   input logic              bus_oe_o,
   input logic              done_o,
   input logic              busy_o,
   input logic              err_o
);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!req_o && !bus_oe_o));

   a_r2_req_next: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (req_o && busy_o));

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ($stable(addr_o) && $stable(rnw_o) && $stable(bus_wdata_o)));

   a_r6_oe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe_o |-> !rnw_o);

   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);

endmodule

bind hs_bus_master hs_bus_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .req_o       (req_o),
   .rnw_o       (rnw_o),
   .addr_o      (addr_o),
   .bus_wdata_o (bus_wdata_o),
   .bus_oe_o    (bus_oe_o),
   .done_o      (done_o),
   .busy_o      (busy_o),
   .err_o       (err_o)
);

// File: tb/hs_bus_master_bench.sv
`timescale 1ns/1ps
module hs_bus_master_bench;

   localparam int AW = 14;
   localparam int DW = 16;
   localparam int SY = 2;
   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          write = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [TW-1:0] tmo_limit = '0;
   logic          req, rnw, oe, done, busy, err;
   logic [AW-1:0] addr_o;
   logic [DW-1:0] bus_wdata, bus_rdata, rdata;
   logic          wait_n;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   hs_bus_master #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SY), .TMO_EN(1'b1), .TMO_W(TW))
   u_hs_bus_master (
      .clk(clk), .rst_n(rst_n), .start_i(start), .write_i(write), .addr_i(addr),
      .wdata_i(wdata), .tmo_limit_i(tmo_limit), .req_o(req), .rnw_o(rnw),
      .addr_o(addr_o), .bus_oe_o(oe), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
      .wait_n_i(wait_n), .rdata_o(rdata), .done_o(done), .busy_o(busy), .err_o(err)
   );

   // ---------------- memory model ----------------
   logic [DW-1:0] mem [16];
   logic [DW-1:0] mem_q;
   logic          mem_drv;
   logic          mute = 1'b0;
   int            d_ack = 0, d_rel = 0;
   int            mcnt;
   int            mem_txn;
   bit            m_acked;
   bit            conflict = 1'b0;
   bit            oe_miss = 1'b0;

   function automatic logic [DW-1:0] init_word(int i);
      return DW'(i * 16'h1111) ^ 16'h5A5A;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
         wait_n <= 1'b1; mem_drv <= 1'b0; mem_q <= '0;
         mcnt <= 0; mem_txn <= 0; m_acked <= 1'b0;
      end else if (!m_acked) begin
         if (req && !mute) begin
            if (mcnt >= d_ack) begin
               wait_n  <= 1'b0;
               m_acked <= 1'b1;
               mcnt    <= 0;
               mem_txn <= mem_txn + 1;
               if (rnw) begin
                  mem_drv <= 1'b1;
                  mem_q   <= mem[addr_o[3:0]];
               end else begin
                  mem[addr_o[3:0]] <= bus_wdata;
                  if (!oe) oe_miss <= 1'b1;
               end
            end else mcnt <= mcnt + 1;
         end
      end else if (!req) begin
         if (mcnt >= d_rel) begin
            wait_n  <= 1'b1;
            mem_drv <= 1'b0;
            m_acked <= 1'b0;
            mcnt    <= 0;
         end else mcnt <= mcnt + 1;
      end
   end

   assign bus_rdata = mem_drv ? mem_q : 16'h0BAD;

   always @(negedge clk) if (mem_drv && oe) conflict <= 1'b1;

   // ---------------- bench helpers ----------------
   logic [DW-1:0] shadow [16];

   function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
      return shadow[a[3:0]];
   endfunction

   task automatic chk(bit ok, string rq, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic xfer(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, bit exp_err, bit poke);
      int txn0, lowcnt, ndone;
      bit prev_req, fell_seen;
      txn0 = mem_txn;
      @(negedge clk);
      start = 1'b1; write = wr; addr = a; wdata = d;
      @(negedge clk);
      start = 1'b0;
      chk(req == 1'b1, "R2", "req after start", req, 1);
      chk(addr_o == a && rnw == !wr, "R2", "addr/dir", {addr_o, rnw}, {a, !wr});
      chk(oe == wr, "R6", "oe at request", oe, wr);
      if (poke) begin
         start = 1'b1; addr = a ^ 1; write = !wr;   // R8: must be ignored
      end
      prev_req = 1'b1; lowcnt = (req && !wait_n) ? 1 : 0; fell_seen = 1'b0;
      do begin
         @(negedge clk);
         start = 1'b0;
         if (prev_req && !req && !fell_seen && !exp_err) begin
            fell_seen = 1'b1;
            chk(lowcnt == SY + 1, "R4", "wait-low cycles before request fell", lowcnt, SY + 1);
         end
         if (req && !wait_n) lowcnt++;
         chk(addr_o == a && rnw == !wr && (wr ? bus_wdata == d : 1'b1), "R3",
             "held address/data", addr_o, a);
         prev_req = req;
      end while (!done && !finished);
      chk(done && !busy, "R7", "done with busy low", {done, busy}, 2'b10);
      chk(err == exp_err, exp_err ? "R9" : "R11", "error flag", err, exp_err);
      if (!wr && !exp_err) chk(rdata == exp_read(a), "R5", "read data", rdata, exp_read(a));
      if (wr && !exp_err) begin
         shadow[a[3:0]] = d;
         chk(mem[a[3:0]] == d, "R6", "write reached memory", mem[a[3:0]], d);
      end
      ndone = 0;
      repeat (6) begin
         @(negedge clk);
         if (done) ndone++;
      end
      chk(ndone == 0, "R7", "extra done cycles", ndone, 0);
      chk(!conflict && !oe_miss, "R6", "bus conflict/oe missing", {conflict, oe_miss}, 0);
      if (!exp_err || !mute)
         chk(mem_txn - txn0 == 1, poke ? "R8" : "R2", "memory transfers", mem_txn - txn0, 1);
      chk(!busy, "R8", "idle after transfer", busy, 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 16; i++) shadow[i] = init_word(i);
      repeat (3) @(negedge clk);
      chk(!req && !oe && !done && !err && !busy, "R1", "reset outputs",
          {req, oe, done, err, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!req && !oe && !busy, "R1", "idle after reset", {req, oe, busy}, 0);

      // directed: read, write, read back, ignored start
      tmo_limit = 8'd0;
      xfer(1'b0, 14'd3, '0, 1'b0, 1'b0);
      xfer(1'b1, 14'd5, 16'hC0DE, 1'b0, 1'b0);
      xfer(1'b0, 14'd5, '0, 1'b0, 1'b0);
      xfer(1'b1, 14'd9, 16'h1234, 1'b0, 1'b1);   // R8
      xfer(1'b0, 14'd9, '0, 1'b0, 1'b1);         // R8
      chk(mem[8] == init_word(8), "R8", "ignored start touched memory", mem[8], init_word(8));

      // R11: ack and expiry coincide (zero-delay memory, SY=2 -> 4th request cycle)
      d_ack = 0; d_rel = 0;
      tmo_limit = 8'd4;
      xfer(1'b0, 14'd7, '0, 1'b0, 1'b0);
      tmo_limit = 8'd3;                           // one cycle short -> timeout R9
      xfer(1'b0, 14'd7, '0, 1'b1, 1'b0);

      // R9: silent memory, request held exactly limit cycles
      begin
         int hi;
         mute = 1'b1; tmo_limit = 8'd10; hi = 0;
         @(negedge clk);
         start = 1'b1; write = 1'b0; addr = 14'd2;
         @(negedge clk);
         start = 1'b0;
         while (req) begin hi++; @(negedge clk); end
         chk(hi == 10, "R9", "request cycles before timeout", hi, 10);
         while (!done && !finished) @(negedge clk);
         chk(err == 1'b1, "R9", "timeout error", err, 1);
         @(negedge clk);
         chk(!err, "R9", "error only with done", err, 0);
      end

      // R10: limit 0 waits indefinitely
      tmo_limit = 8'd0;
      @(negedge clk);
      start = 1'b1; write = 1'b0; addr = 14'd4;
      @(negedge clk);
      start = 1'b0;
      repeat (300) @(negedge clk);
      chk(req && busy && !done, "R10", "still requesting", {req, busy, done}, 3'b110);
      mute = 1'b0;
      while (!done && !finished) @(negedge clk);
      chk(!err && rdata == exp_read(14'd4), "R10", "late ack completes", rdata, exp_read(14'd4));
      repeat (3) @(negedge clk);

      // constrained random mix
      for (int n = 0; n < 60; n++) begin
         bit wr;
         logic [AW-1:0] a;
         d_ack = int'($urandom_range(0, 4));
         d_rel = int'($urandom_range(0, 4));
         tmo_limit = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'd40;
         wr = 1'($urandom_range(0, 1));
         a = AW'($urandom_range(0, 15));
         xfer(wr, a, DW'($urandom), 1'b0, 1'($urandom_range(0, 3) == 0));
      end

      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule